// File: doc/BRIEF.md
# Port-controlled memory bank decoder

This block sits between the CPU of an 8-bit microcomputer and its memories. It maps a 16-bit address space onto four fixed regions: 16 KB of main RAM, 16 KB of video RAM, an 8 KB BASIC ROM and an 8 KB system ROM. Individual output bits of a parallel I/O port switch each region in or out, and one more bit makes main RAM writable or read-only. The block keeps these bits in a register that updates only on a port-write strobe.

For every CPU memory access, qualified by the memory-request strobe together with a read or write strobe, the decoder drives a one-hot region select and the byte offset inside the selected region. It also drives a write enable that honours the read-only setting, and the read byte returned to the CPU. Addresses that no enabled region covers read as 0xFF, and writes to them are dropped. Write data goes from the CPU bus straight to the memories and does not pass through the block.

Top module: `mem_bank_decoder`

## Requirements
- R1: After reset, main RAM (writable), video RAM and system ROM are mapped and BASIC ROM is not, so the start address 0xF000 selects the system ROM.
- R2: Port bit 0 maps the system ROM at 0xE000–0xFFFF (select bit 2), with offset = address[12:0].
- R3: Port bit 1 maps main RAM at 0x0000–0x3FFF (select bit 0), with offset = address[13:0].
- R4: Port bit 2 maps video RAM at 0x8000–0xBFFF (select bit 1), with offset = address[13:0]. It is always writable when mapped.
- R5: Port bit 7 maps the BASIC ROM at 0xC000–0xDFFF (select bit 3), with offset = address[12:0].
- R6: mem_we is 1 only for a write to mapped video RAM, or to mapped main RAM while port bit 3 is 1. Writes to main RAM while bit 3 is 0, and writes to either ROM, give mem_we = 0.
- R7: An access to an address with no mapped region drives select bit 4 and offset 0. A read there returns 0xFF and a write gives mem_we = 0. 0x4000–0x7FFF is always unmapped.
- R8: sel is one-hot only while mreq is 1 together with rd or wr. Otherwise sel and offset are all zero.
- R9: On a read of a mapped region, rdata carries that region's input byte. Whenever no read is under way, rdata is 0xFF.
- R10: Port bits 4, 5 and 6 never alter the map. The map changes only on a clock edge with port_wr high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_wr | input | 1 | Strobe: latch port_data into the map register |
| port_data | input | 8 | Parallel port output bits |
| mreq | input | 1 | CPU memory request |
| rd | input | 1 | CPU read strobe |
| wr | input | 1 | CPU write strobe |
| addr | input | 16 | CPU address |
| ram_rdata | input | 8 | Byte read from main RAM |
| vram_rdata | input | 8 | Byte read from video RAM |
| sys_rdata | input | 8 | Byte read from system ROM |
| bas_rdata | input | 8 | Byte read from BASIC ROM |
| sel | output | 5 | One-hot select: RAM, VRAM, system ROM, BASIC ROM, none |
| offset | output | 14 | Byte offset inside the selected region |
| mem_we | output | 1 | Write enable to the selected RAM |
| rdata | output | 8 | Byte returned to the CPU |

## Verification
The assertions assume that rd and wr are never high in the same cycle. They also assume that the address and strobes are settled whenever the combinational outputs are sampled. The bench changes the address, strobes and port bits only just after a rising edge, raises at most one of rd and wr, and leaves the map alone during accesses. It writes the port only in a separate cycle before a batch of accesses.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int PORT_W   = 8;
  localparam int OFF_W    = 14;
  localparam int NUM_REG  = 4;
  localparam int SEL_W    = NUM_REG + 1;

  // select bit positions
  localparam int SEL_RAM  = 0;
  localparam int SEL_VRAM = 1;
  localparam int SEL_SYS  = 2;
  localparam int SEL_BAS  = 3;
  localparam int SEL_NONE = 4;

  // port bit positions that steer the map
  localparam int PB_SYS  = 0;
  localparam int PB_RAM  = 1;
  localparam int PB_VRAM = 2;
  localparam int PB_RAMW = 3;
  localparam int PB_BAS  = 7;

  typedef struct packed {
    logic bas;
    logic ramw;
    logic vram;
    logic ram;
    logic sys;
  } map_t;

  localparam map_t MAP_RESET = '{bas: 1'b0, ramw: 1'b1, vram: 1'b1, ram: 1'b1, sys: 1'b1};

  function automatic map_t port_to_map(input logic [PORT_W-1:0] p);
    map_t m;
    m.bas  = p[PB_BAS];
    m.ramw = p[PB_RAMW];
    m.vram = p[PB_VRAM];
    m.ram  = p[PB_RAM];
    m.sys  = p[PB_SYS];
    return m;
  endfunction

  function automatic logic [ADDR_W-1:0] region_base(input int i);
    case (i)
      SEL_RAM:  return 16'h0000;
      SEL_VRAM: return 16'h8000;
      SEL_SYS:  return 16'hE000;
      default:  return 16'hC000;
    endcase
  endfunction

  function automatic int region_lg2(input int i);
    case (i)
      SEL_RAM, SEL_VRAM: return 14;
      default:           return 13;
    endcase
  endfunction
endpackage

// File: rtl/mbd_cfg_reg.sv
module mbd_cfg_reg
  import mbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_wr,
  input  logic [PORT_W-1:0] port_data,
  output map_t              map_q
);
  logic [1:0] rsync_q;
  logic       rst_int_n;
  map_t       map_d;
  logic       map_en;
  logic       unused_port_bits;

  assign unused_port_bits = ^port_data[6:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  always_comb begin
    map_d  = port_to_map(port_data);
    map_en = port_wr && rst_int_n && (map_d != map_q);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  map_q <= MAP_RESET;
    else if (map_en) map_q <= map_d;
  end
endmodule

// File: rtl/mbd_region_decode.sv
module mbd_region_decode
  import mbd_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  logic               access,
  input  logic [NUM_REG-1:0] region_en,
  output logic [SEL_W-1:0]   sel,
  output logic [OFF_W-1:0]   offset
);
  logic [NUM_REG-1:0]            hit;
  logic [NUM_REG-1:0][OFF_W-1:0] off_hit;

  for (genvar i = 0; i < NUM_REG; i++) begin : g_region
    localparam int                LG   = region_lg2(i);
    localparam logic [ADDR_W-1:0] BASE = region_base(i);
    assign hit[i]     = region_en[i] && (addr[ADDR_W-1:LG] == BASE[ADDR_W-1:LG]);
    assign off_hit[i] = hit[i] ? OFF_W'(addr[LG-1:0]) : '0;
  end

  always_comb begin
    logic [OFF_W-1:0] o;
    o = '0;
    for (int i = 0; i < NUM_REG; i++) o = o | off_hit[i];
    sel              = '0;
    sel[NUM_REG-1:0] = access ? hit : '0;
    sel[SEL_NONE]    = access && (hit == '0);
    offset           = access ? o : '0;
  end
endmodule

// File: rtl/mbd_data_path.sv
module mbd_data_path
  import mbd_pkg::*;
(
  input  logic [SEL_W-1:0]              sel,
  input  logic                          rd,
  input  logic                          wr,
  input  logic                          ram_writable,
  input  logic [NUM_REG-1:0][DATA_W-1:0] region_rdata,
  output logic                          mem_we,
  output logic [DATA_W-1:0]             rdata
);
  always_comb begin
    mem_we = wr && ((sel[SEL_RAM] && ram_writable) || sel[SEL_VRAM]);
    rdata  = '1;
    if (rd) begin
      for (int i = 0; i < NUM_REG; i++) begin
        if (sel[i]) rdata = region_rdata[i];
      end
    end
  end
endmodule

// File: rtl/mem_bank_decoder.sv
module mem_bank_decoder
  import mbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_wr,
  input  logic [PORT_W-1:0] port_data,
  input  logic              mreq,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] vram_rdata,
  input  logic [DATA_W-1:0] sys_rdata,
  input  logic [DATA_W-1:0] bas_rdata,
  output logic [SEL_W-1:0]  sel,
  output logic [OFF_W-1:0]  offset,
  output logic              mem_we,
  output logic [DATA_W-1:0] rdata
);
  map_t                          map_q;
  logic [NUM_REG-1:0]            region_en;
  logic [NUM_REG-1:0][DATA_W-1:0] region_rdata;
  logic                          access;

  assign access = mreq && (rd || wr);

  always_comb begin
    region_en[SEL_RAM]     = map_q.ram;
    region_en[SEL_VRAM]    = map_q.vram;
    region_en[SEL_SYS]     = map_q.sys;
    region_en[SEL_BAS]     = map_q.bas;
    region_rdata[SEL_RAM]  = ram_rdata;
    region_rdata[SEL_VRAM] = vram_rdata;
    region_rdata[SEL_SYS]  = sys_rdata;
    region_rdata[SEL_BAS]  = bas_rdata;
  end

  mbd_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_wr   (port_wr),
    .port_data (port_data),
    .map_q     (map_q)
  );

  mbd_region_decode u_dec (
    .addr      (addr),
    .access    (access),
    .region_en (region_en),
    .sel       (sel),
    .offset    (offset)
  );

  mbd_data_path u_dp (
    .sel          (sel),
    .rd           (rd),
    .wr           (wr),
    .ram_writable (map_q.ramw),
    .region_rdata (region_rdata),
    .mem_we       (mem_we),
    .rdata        (rdata)
  );
endmodule

// File: rtl/mbd_checker.sv
module mbd_checker
  import mbd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              port_wr,
  input logic [PORT_W-1:0] port_data,
  input logic              mreq,
  input logic              rd,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [SEL_W-1:0]  sel,
  input logic [OFF_W-1:0]  offset,
  input logic              mem_we,
  input logic [DATA_W-1:0] rdata,
  input map_t              map_q
);
  // R8
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  // R8
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mreq && (rd || wr)) |-> (sel == '0 && offset == '0));

  // R7
  none_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[SEL_NONE] && rd) |-> (rdata == 8'hFF && !mem_we));

  // R7
  gap_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq && (rd || wr) && addr[15:14] == 2'b01) |-> sel[SEL_NONE]);

  // R6
  we_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mreq && wr && (sel[SEL_RAM] || sel[SEL_VRAM])));

  // R6
  ram_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[SEL_RAM] && !map_q.ramw) |-> !mem_we);

  // R2
  sys_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel[SEL_SYS] |-> (addr[15:13] == 3'b111));

  // R10
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_wr |=> $stable(map_q));

  // R10
  ignored_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && port_to_map(port_data) == map_q) |=> $stable(map_q));
endmodule

bind mem_bank_decoder mbd_checker u_chk (.*);

// File: tb/tb_mem_bank_decoder.sv
module tb_mem_bank_decoder;
  logic        clk;
  logic        rst_n;
  logic        port_wr;
  logic [7:0]  port_data;
  logic        mreq, rd, wr;
  logic [15:0] addr;
  logic [7:0]  ram_rdata, vram_rdata, sys_rdata, bas_rdata;
  logic [4:0]  sel;
  logic [13:0] offset;
  logic        mem_we;
  logic [7:0]  rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [7:0] model_port;

  logic [27:0] exp_q[$];
  string       tag_q[$];

  mem_bank_decoder dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // reference: returns {sel, offset, we, rdata}
  function automatic logic [27:0] ref_out(input logic [7:0] p, input logic [15:0] a,
                                          input logic m, input logic r, input logic w,
                                          output int id);
    logic [4:0]  s;
    logic [13:0] o;
    logic        we;
    logic [7:0]  d;
    id = 4;
    o  = '0;
    if (a[15:14] == 2'b00 && p[1])       begin id = 0; o = a[13:0]; end
    else if (a[15:14] == 2'b10 && p[2])  begin id = 1; o = a[13:0]; end
    else if (a[15:13] == 3'b111 && p[0]) begin id = 2; o = {1'b0, a[12:0]}; end
    else if (a[15:13] == 3'b110 && p[7]) begin id = 3; o = {1'b0, a[12:0]}; end
    s = '0; we = 1'b0; d = 8'hFF;
    if (m && (r || w)) begin
      s = 5'b00001 << id;
      we = w && ((id == 0 && p[3]) || id == 1);
      if (r) begin
        case (id)
          0: d = 8'hA1;
          1: d = 8'hB2;
          2: d = 8'hC3;
          3: d = 8'hD4;
          default: d = 8'hFF;
        endcase
      end
    end else begin
      o = '0;
    end
    return {s, o, we, d};
  endfunction

  task automatic access(input logic [15:0] a, input logic m, input logic r, input logic w,
                        input string tag);
    int id;
    logic [27:0] e;
    @(posedge clk); #1;
    addr = a; mreq = m; rd = r; wr = w;
    e = ref_out(model_port, a, m, r, w, id);
    exp_q.push_back(e);
    if (tag != "") tag_q.push_back(tag);
    else if (id == 4)    tag_q.push_back("R7");
    else if (id == 0)    tag_q.push_back(w ? "R6" : "R3");
    else if (id == 1)    tag_q.push_back("R4");
    else if (id == 2)    tag_q.push_back("R2");
    else                 tag_q.push_back("R5");
  endtask

  task automatic set_port(input logic [7:0] v);
    @(posedge clk); #1;
    mreq = 0; rd = 0; wr = 0;
    port_data = v; port_wr = 1;
    @(posedge clk); #1;
    port_wr = 0;
    model_port = v;
  endtask

  // monitor: compares one scoreboard item per falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [27:0] e;
      logic [27:0] act;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      act = {sel, offset, mem_we, rdata};
      checks++;
      if (act !== e) begin
        errors++;
        $display("FAIL %s addr=%h actual sel=%b off=%h we=%b rd=%h expected sel=%b off=%h we=%b rd=%h",
                 t, addr, act[27:23], act[22:9], act[8], act[7:0], e[27:23], e[22:9], e[8], e[7:0]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] pts [11] = '{16'h0000, 16'h3FFF, 16'h4000, 16'h7FFF, 16'h8000, 16'hBFFF,
                              16'hC000, 16'hDFFF, 16'hE000, 16'hF000, 16'hFFFF};
    rst_n = 0; port_wr = 0; port_data = 8'h00;
    mreq = 0; rd = 0; wr = 0; addr = 16'h0000;
    ram_rdata = 8'hA1; vram_rdata = 8'hB2; sys_rdata = 8'hC3; bas_rdata = 8'hD4;
    model_port = 8'h0F;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);

    // R1: reset map, start address in system ROM
    access(16'hF000, 1, 1, 0, "R1");
    access(16'h0000, 1, 0, 1, "R1");
    access(16'hC000, 1, 1, 0, "R1");
    access(16'h8000, 1, 0, 1, "R1");

    // R8: no access without strobes
    access(16'h0000, 0, 1, 0, "R8");
    access(16'hE123, 1, 0, 0, "R8");
    access(16'h8001, 0, 0, 1, "R8");

    // R9: read data routing and idle 0xFF
    access(16'hE456, 1, 1, 0, "R9");
    access(16'h1234, 1, 1, 0, "R9");
    access(16'h1234, 1, 0, 1, "R9");

    // all 32 enable combinations at each boundary
    for (int c = 0; c < 32; c++) begin
      logic [4:0] cb;
      cb = 5'(c);
      set_port({cb[4], 3'b000, cb[3:0]});
      foreach (pts[k]) begin
        access(pts[k], 1, 1, 0, "");
        access(pts[k], 1, 0, 1, "");
      end
    end

    // R10: bits 4..6 ignored, map only moves on port_wr
    set_port(8'h0F);
    set_port(8'h7F);
    model_port = 8'h0F;
    access(16'hC000, 1, 1, 0, "R10");
    access(16'h0010, 1, 0, 1, "R10");
    @(posedge clk); #1 port_data = 8'h80;
    access(16'hC000, 1, 1, 0, "R10");
    access(16'h0010, 1, 0, 1, "R10");
    access(16'hE000, 1, 1, 0, "R10");

    // R6: read-only main RAM
    set_port(8'h03);
    access(16'h2000, 1, 0, 1, "R6");
    access(16'h2000, 1, 1, 0, "R6");

    repeat (4) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule